// File: doc/BRIEF.md
# Programmable Speaker Tone Control

This block produces the one-bit logic-level drive for a small speaker. Three methods can feed that bit, alone or together. Software can flip a drive-enable bit by hand. A down-counting tone generator can produce a square wave. A gate bit can start, stop and restart that tone generator from software. The final output is the tone waveform ANDed with the drive-enable bit. While the gate is off, the tone is held high, so the drive-enable bit alone sets the output.

Software reaches the block through a byte-wide write port and a combinational read port. There are two addresses. Address 0 is the control register. Address 1 is the divisor port, which takes the tone divisor as a run of bytes, least significant byte first. The divisor takes effect on the last byte. The waveform then restarts at the start of its high phase.

Top module: `spk_tone_ctrl`

## Requirements
- R1: After reset, `spk_out` is 0 and a read of address 0 returns 8'h04: gate off, drive off, tone level high.
- R2: When the gate bit (bit 0 of address 0) is 0, `spk_out` equals the drive-enable bit (bit 1 of address 0) in the cycle after each control write.
- R3: Clearing the gate holds the tone level high and parks the counter. Setting the gate again restarts the waveform from the first cycle of its high phase.
- R4: The divisor is written to address 1 as two bytes, low byte then high byte. A low byte on its own leaves the waveform unchanged. The high byte loads the full value and restarts the waveform.
- R5: With gate set and divisor N ≥ 1, the tone level is high for ceil(N/2) clocks and then low for floor(N/2) clocks, repeating. The first high cycle is the cycle after the load or the gate rise. N=1 gives a constant high.
- R6: A divisor of 0 acts as 65536: the tone is high for 32768 clocks and then low for 32768 clocks.
- R7: `spk_out` is the tone level ANDed with the drive-enable bit. With drive-enable at 0, the output stays 0 while the tone runs.
- R8: Bit 2 of a read of address 0 returns the current tone level, that is, the waveform after the gate forcing.
- R9: Write bits 7:2 of address 0 are ignored and read back as 0. Reads of address 1 return 8'h00.
- R10: Until the first complete divisor load, the tone level stays high even when the gate is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one byte per asserted cycle |
| bus_addr | input | 1 | 0 selects control, 1 selects divisor port |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| spk_out | output | 1 | Logic-level speaker drive |

## Verification
A wrong phase or reload in the counter changes the high/low run lengths on `spk_out` and on the read-back tone bit. This shows within one divisor period, or at the first phase boundary after a load or a gate rise. The bench checks every sample of each waveform, so a slip of one cycle is caught. A wrong byte-sequencing state shows up as a waveform that starts or changes on the wrong divisor write. A wrong control bit shows on `spk_out` in the cycle after the write.

// File: rtl/spk_pkg.sv
package spk_pkg;
    localparam int BYTE_W = 8;

    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_DIV  = 1'b1;

    localparam int CTRL_GATE_BIT  = 0;
    localparam int CTRL_DRIVE_BIT = 1;
    localparam int CTRL_TONE_BIT  = 2;
endpackage

// File: rtl/spk_regs.sv
module spk_regs
    import spk_pkg::*;
#(
    parameter int DIV_BYTES = 2,
    localparam int DIV_W = DIV_BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  logic              tone_i,
    output logic              gate_o,
    output logic              drive_o,
    output logic              load_o,
    output logic [DIV_W-1:0]  load_val_o,
    output logic [BYTE_W-1:0] bus_rdata
);
    localparam int LO_W  = DIV_W - BYTE_W;
    localparam int IDX_W = (DIV_BYTES > 2) ? $clog2(DIV_BYTES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DIV_BYTES - 1);

    typedef struct packed {
        logic             gate;
        logic             drive;
        logic [IDX_W-1:0] idx;
        logic [LO_W-1:0]  lo;
    } regs_t;

    regs_t s_q, s_d;
    logic [LO_W-1:0] lo_shift;
    logic            wr_ctrl, wr_div;

    // lower bytes gather into a right-shifting store, first byte lowest
    generate
        if (LO_W == BYTE_W) begin : g_two_bytes
            assign lo_shift = bus_wdata;
        end else begin : g_many_bytes
            assign lo_shift = {bus_wdata, s_q.lo[LO_W-1:BYTE_W]};
        end
    endgenerate

    assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
    assign wr_div  = bus_wr && (bus_addr == ADDR_DIV);

    always_comb begin
        s_d = s_q;
        if (wr_ctrl) begin
            s_d.gate  = bus_wdata[CTRL_GATE_BIT];
            s_d.drive = bus_wdata[CTRL_DRIVE_BIT];
        end
        if (wr_div) begin
            if (s_q.idx == LAST_IDX) begin
                s_d.idx = '0;
            end else begin
                s_d.idx = s_q.idx + 1'b1;
                s_d.lo  = lo_shift;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign gate_o     = s_q.gate;
    assign drive_o    = s_q.drive;
    assign load_o     = wr_div && (s_q.idx == LAST_IDX);
    assign load_val_o = {bus_wdata, s_q.lo};

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_CTRL) begin
            bus_rdata[CTRL_GATE_BIT]  = s_q.gate;
            bus_rdata[CTRL_DRIVE_BIT] = s_q.drive;
            bus_rdata[CTRL_TONE_BIT]  = tone_i;
        end
    end

    // R4: a full load leaves the byte sequencer waiting for a fresh low byte
    a_r4_seq_restart: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> (s_q.idx == '0));

    // R9: divisor writes never disturb the control bits
    a_r9_ctrl_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_DIV) |=> ($stable(s_q.gate) && $stable(s_q.drive)));
endmodule

// File: rtl/spk_tone_counter.sv
module spk_tone_counter #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate_i,
    input  logic             load_i,
    input  logic [DIV_W-1:0] load_val_i,
    output logic             tone_o
);
    // a stored period of 0 stands for 2**DIV_W
    typedef struct packed {
        logic             armed;
        logic [DIV_W-1:0] period;
        logic [DIV_W-1:0] cnt;
    } cnt_t;

    cnt_t s_q, s_d;
    logic [DIV_W-1:0] last_q;
    logic [DIV_W-1:0] last_new;
    logic [DIV_W-1:0] half;

    assign last_q   = s_q.period - 1'b1;
    assign last_new = load_val_i - 1'b1;
    assign half     = (s_q.period == '0) ? {1'b1, {(DIV_W-1){1'b0}}}
                                         : (s_q.period >> 1);

    always_comb begin
        s_d = s_q;
        if (load_i) begin
            s_d.armed  = 1'b1;
            s_d.period = load_val_i;
            s_d.cnt    = last_new;
        end else if (!gate_i || !s_q.armed) begin
            s_d.cnt = last_q;
        end else if (s_q.cnt == '0) begin
            s_d.cnt = last_q;
        end else begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tone_o = !gate_i || !s_q.armed || (s_q.cnt >= half);

    // R5: every reload starts in the high phase
    a_r5_load_high: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && gate_i) |=> (tone_o || !gate_i));

    // R5: a finished period wraps back to its top count
    a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_i && s_q.armed && !load_i && s_q.cnt == '0)
        |=> (s_q.cnt == $past(last_q)));

    // R6: the count never leaves the period range (0 stands for the full range)
    always_comb begin
        if (rst_n && s_q.armed && s_q.period != '0)
            a_r6_in_range: assert (s_q.cnt < s_q.period);
    end
endmodule

// File: rtl/spk_tone_ctrl.sv
module spk_tone_ctrl
    import spk_pkg::*;
#(
    parameter int DIV_BYTES = 2,
    localparam int DIV_W = DIV_BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              spk_out
);
    logic             gate, drive, load, tone;
    logic [DIV_W-1:0] load_val;

    spk_regs #(.DIV_BYTES(DIV_BYTES)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .tone_i     (tone),
        .gate_o     (gate),
        .drive_o    (drive),
        .load_o     (load),
        .load_val_o (load_val),
        .bus_rdata  (bus_rdata)
    );

    spk_tone_counter #(.DIV_W(DIV_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .gate_i     (gate),
        .load_i     (load),
        .load_val_i (load_val),
        .tone_o     (tone)
    );

    assign spk_out = tone & drive;

    // R2: with the gate off the register bit alone drives the speaker
    a_r2_direct: assert property (@(posedge clk) disable iff (!rst_n)
        !gate |-> (spk_out == drive));

    // R10: no waveform before the first complete divisor load
    a_r10_unloaded_high: assert property (@(posedge clk) disable iff (!rst_n)
        (drive && !$past(load) && $past(!u_cnt.s_q.armed) && !load) |-> spk_out);
endmodule

// File: tb/sim_spk_tone_ctrl.sv
module sim_spk_tone_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       spk_out;
    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    spk_tone_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spk_out(spk_out)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // write one byte; returns at the negedge after the capturing edge
    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 1'b0; bus_wdata = 8'h00;
        #0.1;
    endtask

    task automatic load_div(input logic [15:0] n);
        wr(1'b1, n[7:0]);
        wr(1'b1, n[15:8]);
    endtask

    // sample-by-sample compare against ceil/floor phases of period n
    task automatic check_wave(input string req, input int n, input int total, input logic drv);
        int bad = 0;
        logic tone_e, spk_e;
        for (int i = 0; i < total; i++) begin
            tone_e = ((i % n) < ((n + 1) / 2));
            spk_e  = tone_e & drv;
            if (spk_out !== spk_e || bus_rdata[2] !== tone_e) begin
                if (bad == 0)
                    $display("FAIL %s sample %0d spk_out=%b tone_bit=%b expected %b/%b",
                             req, i, spk_out, bus_rdata[2], spk_e, tone_e);
                bad++;
            end
            @(negedge clk);
            #0.1;
        end
        checks++;
        if (bad != 0) failures++;
    endtask

    task automatic check_steady(input string req, input logic spk_e, input logic tone_e, input int total);
        int bad = 0;
        for (int i = 0; i < total; i++) begin
            if (spk_out !== spk_e || bus_rdata[2] !== tone_e) begin
                if (bad == 0)
                    $display("FAIL %s sample %0d spk_out=%b tone_bit=%b expected %b/%b",
                             req, i, spk_out, bus_rdata[2], spk_e, tone_e);
                bad++;
            end
            @(negedge clk);
            #0.1;
        end
        checks++;
        if (bad != 0) failures++;
    endtask

    task automatic t_reset;
        check("R1 spk_out after reset", {7'b0, spk_out}, 8'h00);
        check("R1 R8 control read after reset", bus_rdata, 8'h04);
    endtask

    task automatic t_direct;
        wr(1'b0, 8'h02);
        check("R2 drive on", {7'b0, spk_out}, 8'h01);
        check("R2 control read", bus_rdata, 8'h06);
        wr(1'b0, 8'h00);
        check("R2 drive off", {7'b0, spk_out}, 8'h00);
        wr(1'b0, 8'h02);
        check("R2 drive on again", {7'b0, spk_out}, 8'h01);
    endtask

    task automatic t_reserved;
        wr(1'b0, 8'hFE);
        check("R9 reserved bits dropped", bus_rdata, 8'h06);
        check("R9 spk_out follows drive", {7'b0, spk_out}, 8'h01);
        @(negedge clk);
        bus_addr = 1'b1;
        #0.1;
        check("R9 divisor port reads zero", bus_rdata, 8'h00);
        bus_addr = 1'b0;
        wr(1'b0, 8'h00);
    endtask

    task automatic t_unloaded;
        wr(1'b0, 8'h03);
        check_steady("R10 gate on, no divisor", 1'b1, 1'b1, 12);
        wr(1'b1, 8'h05);
        check_steady("R4 low byte alone", 1'b1, 1'b1, 12);
        wr(1'b1, 8'h00);
        check_wave("R4 R5 N=5", 5, 20, 1'b1);
    endtask

    task automatic t_periods;
        load_div(16'd4);
        check_wave("R5 N=4", 4, 16, 1'b1);
        load_div(16'd1);
        check_wave("R5 N=1", 1, 8, 1'b1);
        load_div(16'd259);
        check_wave("R4 R5 N=259 high byte", 259, 300, 1'b1);
    endtask

    task automatic t_gate;
        load_div(16'd6);
        check_wave("R5 N=6 before gate off", 6, 7, 1'b1);
        wr(1'b0, 8'h02);
        check_steady("R3 gate off holds high", 1'b1, 1'b1, 10);
        wr(1'b0, 8'h03);
        check_wave("R3 gate restart", 6, 18, 1'b1);
        wr(1'b0, 8'h00);
        wr(1'b0, 8'h01);
        check_wave("R7 R8 drive masked", 6, 12, 1'b0);
        wr(1'b0, 8'h03);
    endtask

    task automatic t_zero;
        load_div(16'd0);
        check_wave("R6 N=0 as 65536", 65536, 65540, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL watchdog expired actual=running expected=done");
        failures++;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #0.1;
        t_reset();
        t_direct();
        t_reserved();
        t_unloaded();
        t_periods();
        t_gate();
        t_zero();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule